// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block drives an external analog-to-digital converter through a start/done handshake. It keeps one result register per channel and reports completion through a status flag and an interrupt request. Software controls it through one 8-bit control byte. That byte holds a done flag, an interrupt enable, a run bit, a mode bit and a channel field. A conversion run can also be launched from an external active-low trigger pin.

In single mode the block converts the selected channel once and then stops by itself. In scan mode it converts channels 0 up to the selected channel in ascending order and wraps back to 0. It keeps repeating until software clears the run bit or standby is raised. A DMA engine that services the completion interrupt clears the done flag by pulsing its access strobe.

Control byte layout: bit 7 done flag, bit 6 interrupt enable, bit 5 run, bit 4 scan mode (1 = scan, 0 = single), bits 3:2 read 0, bits 1:0 channel field (NCH = 4).

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, `irq` is 0 and every result register reads 0.
- R2: In single mode (bit 4 = 0), writing bit 5 = 1 converts the channel held in bits 1:0 once. The result goes to that channel's register, bit 7 is set and bit 5 returns to 0 by itself.
- R3: In scan mode (bit 4 = 1) channels 0..field are converted in ascending order and stored per channel. Bit 7 is set once the last channel of a pass completes, and conversion continues from channel 0.
- R4: Software clears bit 7 only by writing bit 7 = 0 after a control read made while bit 7 was 1. A write of 0 without such a read leaves bit 7 at 1, and writing 1 never sets it.
- R5: A pulse on `dma_acc` clears bit 7.
- R6: `irq` is 1 exactly when bit 7 and bit 6 are both 1.
- R7: Bit 5 reads 1 while conversions run. Writing bit 5 = 0 in scan mode stops issuing conversions.
- R8: Raising `standby` clears bit 5 on the next clock and stops conversion.
- R9: A write changes bit 4 only while bit 5 is 0. While running, bit 4 keeps its value.
- R10: `trig_n` passes through a two-flop synchroniser. Its falling edge sets bit 5 when bit 5 is 0. A falling edge while running and any rising edge have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_rd | input | 1 | Control byte read strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control byte read value |
| res_sel | input | 2 | Result register select |
| res_rdata | output | 10 | Selected result value |
| dma_acc | input | 1 | DMA result access strobe, clears done flag |
| trig_n | input | 1 | Asynchronous external start, falling edge |
| standby | input | 1 | Standby request, halts conversion |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_ch | output | 2 | Channel for the conversion being started |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 10 | Converter result, valid with conv_done |
| irq | output | 1 | Completion interrupt request |

## Verification
The bench builds the block with NCH = 4 and RW = 10. The converter model answers six cycles after each start. Four channels let the random single-mode runs reach every value of the channel field. They also let a scan pass of three channels show both the ascending order and the wrap from the last channel back to 0. The six-cycle latency leaves room to land a second trigger edge and a mode write while a conversion is still in flight.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NCH = 4,
  parameter int RW  = 10,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          ctl_rd,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic [CW-1:0] res_sel,
  output logic [RW-1:0] res_rdata,
  input  logic          dma_acc,
  input  logic          trig_n,
  input  logic          standby,
  output logic          conv_start,
  output logic [CW-1:0] conv_ch,
  input  logic          conv_done,
  input  logic [RW-1:0] conv_data,
  output logic          irq
);

  logic          done_f, ie, go, scan, armed, busy, start_q;
  logic [CW-1:0] chsel, cur, ch_q;
  logic [2:0]    tsync;
  logic [RW-1:0] res [NCH];

  wire trig_fall = tsync[2] & ~tsync[1];
  wire fin       = conv_done & busy & go;
  wire last      = ~scan | (ch_q >= chsel);
  wire clr_sw    = ctl_wr & ~ctl_wdata[7] & armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_f  <= 1'b0;
      ie      <= 1'b0;
      go      <= 1'b0;
      scan    <= 1'b0;
      armed   <= 1'b0;
      busy    <= 1'b0;
      start_q <= 1'b0;
      chsel   <= '0;
      cur     <= '0;
      ch_q    <= '0;
      tsync   <= 3'b111;
      for (int i = 0; i < NCH; i++) res[i] <= '0;
    end else begin
      tsync <= {tsync[1:0], trig_n};

      if (ctl_wr) begin
        ie    <= ctl_wdata[6];
        chsel <= ctl_wdata[CW-1:0];
        if (!go) scan <= ctl_wdata[4];
      end

      if (fin && !scan)      go <= 1'b0;
      if (ctl_wr)            go <= ctl_wdata[5];
      else if (trig_fall && !go) go <= 1'b1;
      if (standby)           go <= 1'b0;

      start_q <= 1'b0;
      if (conv_done) busy <= 1'b0;
      if (go && !busy && !start_q && !standby) begin
        start_q <= 1'b1;
        busy    <= 1'b1;
        ch_q    <= scan ? cur : chsel;
      end

      if (!go) cur <= '0;
      else if (fin && scan) cur <= last ? '0 : CW'(ch_q + 1'b1);

      if (fin) res[ch_q] <= conv_data;

      if (ctl_rd && done_f) armed <= 1'b1;
      if (ctl_wr || dma_acc) armed <= 1'b0;

      if (clr_sw || dma_acc) done_f <= 1'b0;
      if (fin && last)       done_f <= 1'b1;
    end
  end

  assign ctl_rdata  = {done_f, ie, go, scan, 4'(chsel)};
  assign res_rdata  = res[res_sel];
  assign conv_start = start_q;
  assign conv_ch    = ch_q;
  assign irq        = done_f & ie;

endmodule

module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [7:0] ctl_wdata,
  input logic       dma_acc,
  input logic       standby,
  input logic       done_f,
  input logic       armed,
  input logic       go,
  input logic       scan,
  input logic       busy,
  input logic       conv_done
);

  assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_f && !dma_acc && !(ctl_wr && !ctl_wdata[7] && armed)) |=> done_f);

  assert_dma_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_acc && !conv_done) |=> !done_f);

  assert_single_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !scan && busy && conv_done && !ctl_wr && !standby) |=> (!go && done_f));

  assert_standby_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !go);

  assert_mode_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && go) |=> $stable(scan));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .dma_acc(dma_acc), .standby(standby), .done_f(done_f), .armed(armed),
  .go(go), .scan(scan), .busy(busy), .conv_done(conv_done)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
  localparam int NCH = 4;
  localparam int RW  = 10;
  localparam int LAT = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, ctl_rd = 0, dma_acc = 0, trig_n = 1, standby = 0;
  logic [7:0] ctl_wdata = 0, ctl_rdata;
  logic [1:0] res_sel = 0, conv_ch;
  logic [RW-1:0] res_rdata, conv_data;
  logic conv_start, conv_done, irq;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  adc_seq_ctrl #(.NCH(NCH), .RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .res_sel(res_sel),
    .res_rdata(res_rdata), .dma_acc(dma_acc), .trig_n(trig_n),
    .standby(standby), .conv_start(conv_start), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_data(conv_data), .irq(irq));

  // converter model: fixed latency responder
  int cnt = 0, nlog = 0, seq = 0;
  logic [1:0] pend_ch = 0;
  logic [1:0] clog [64];
  logic [RW-1:0] sent [NCH];
  initial for (int i = 0; i < NCH; i++) sent[i] = '0;

  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) begin
      pend_ch <= conv_ch;
      cnt     <= LAT;
    end else if (cnt == 1) begin
      conv_done         <= 1'b1;
      conv_data         <= RW'((seq * 53 + int'(pend_ch) * 7 + 1) & ((1 << RW) - 1));
      sent[pend_ch]     <= RW'((seq * 53 + int'(pend_ch) * 7 + 1) & ((1 << RW) - 1));
      clog[nlog % 64]   <= pend_ch;
      nlog              <= nlog + 1;
      seq               <= seq + 1;
      cnt               <= 0;
    end else if (cnt > 0) cnt <= cnt - 1;
  end

  function automatic logic [7:0] mk(bit f, bit e, bit g, bit s, int ch);
    return {f, e, g, s, 2'b00, 2'(ch)};
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); ctl_wr = 1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); ctl_rd = 1;
    v = ctl_rdata;
    @(negedge clk); ctl_rd = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_stop();
    for (int i = 0; i < 200 && ctl_rdata[5]; i++) @(negedge clk);
  endtask

  task automatic clear_flag();
    logic [7:0] v;
    rd(v);
    wr(8'h00);
  endtask

  initial begin
    #(4ns * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n0, ch, e;
    void'($urandom(32'd20240611));
    idle(3); rst_n = 1; @(negedge clk);

    check("R1 ctl", ctl_rdata, 8'h00);
    check("R1 irq", irq, 0);
    for (int i = 0; i < NCH; i++) begin
      res_sel = 2'(i); #1;
      check("R1 result", res_rdata, 0);
    end

    // random single conversions: R2, R6
    for (int it = 0; it < 12; it++) begin
      ch = $urandom % NCH; e = $urandom % 2;
      clear_flag();
      wr(mk(0, e[0], 1, 0, ch));
      check("R7 run bit", ctl_rdata[5], 1);
      wait_stop(); idle(1);
      check("R2 auto stop", ctl_rdata[5], 0);
      check("R2 flag", ctl_rdata[7], 1);
      check("R6 irq", irq, e);
      res_sel = 2'(ch); #1;
      check("R2 result", res_rdata, sent[ch]);
    end

    // R4 clear rules
    clear_flag();
    wr(mk(0, 1, 1, 0, 1)); wait_stop(); idle(1);
    wr(mk(0, 1, 0, 0, 1));
    check("R4 no read no clear", ctl_rdata[7], 1);
    check("R6 irq set", irq, 1);
    rd(v);
    check("R4 read value", v[7], 1);
    wr(mk(1, 1, 0, 0, 1));
    check("R4 write 1 keeps", ctl_rdata[7], 1);
    rd(v);
    wr(mk(0, 1, 0, 0, 1));
    check("R4 cleared", ctl_rdata[7], 0);
    check("R6 irq low", irq, 0);

    // R5 DMA clear
    wr(mk(0, 0, 1, 0, 3)); wait_stop(); idle(1);
    check("R5 flag before", ctl_rdata[7], 1);
    @(negedge clk); dma_acc = 1; @(negedge clk); dma_acc = 0;
    check("R5 dma clear", ctl_rdata[7], 0);

    // R3 scan of channels 0..2
    wr(mk(0, 0, 0, 1, 2));
    n0 = nlog;
    wr(mk(0, 0, 1, 1, 2));
    for (int i = 0; i < 200 && !ctl_rdata[7]; i++) @(negedge clk);
    check("R3 pass count", nlog - n0, 3);
    for (int i = 0; i < 3; i++) begin
      check("R3 order", clog[(n0 + i) % 64], i);
      res_sel = 2'(i); #1;
      check("R3 result", res_rdata, sent[i]);
    end
    check("R7 running", ctl_rdata[5], 1);
    wr(mk(0, 0, 1, 0, 2));
    check("R9 mode locked", ctl_rdata[4], 1);
    for (int i = 0; i < 200 && nlog < n0 + 6; i++) @(negedge clk);
    for (int i = 3; i < 6; i++) check("R3 wrap order", clog[(n0 + i) % 64], i - 3);
    wr(mk(0, 0, 0, 1, 2));
    idle(LAT + 4);
    check("R7 stopped", ctl_rdata[5], 0);
    n0 = nlog; idle(20);
    check("R7 no more conversions", nlog - n0, 0);

    // R8 standby
    wr(mk(0, 0, 1, 1, 2)); idle(10);
    @(negedge clk); standby = 1; @(negedge clk); standby = 0;
    check("R8 standby halt", ctl_rdata[5], 0);
    idle(LAT + 4); n0 = nlog; idle(20);
    check("R8 no conversions", nlog - n0, 0);
    wr(mk(0, 0, 0, 0, 0));
    check("R9 mode change idle", ctl_rdata[4], 0);

    // R10 trigger
    n0 = nlog;
    @(negedge clk); trig_n = 0;
    idle(4);
    check("R10 fall starts", ctl_rdata[5], 1);
    trig_n = 1; idle(1); trig_n = 0;
    wait_stop(); idle(10);
    check("R10 fall while running ignored", nlog - n0, 1);
    check("R10 stopped", ctl_rdata[5], 0);
    trig_n = 1; idle(10);
    check("R10 rise no effect", ctl_rdata[5], 0);
    check("R10 rise no conversion", nlog - n0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule